// File: doc/BRIEF.md
# Flash Write Buffer Load Controller

This block runs the buffered-program command flow of a NOR-style flash device. It watches decoded bus write cycles. After the two-cycle unlock prefix and a write-to-buffer command at a target sector, it takes a word count. It then collects that many plus one address/data pairs into a one-page buffer. Each pair is stored at the location named by the low address bits of its write.

A confirm write at the same sector hands the page to a programming engine through a start pulse. The pulse waits while the engine reports busy. When the engine signals done, the buffer empties and the block returns to idle.

Any rule broken during the flow raises a sticky abort flag. That flag clears only through a dedicated three-write reset sequence.

Top module: `flash_wbuf_loader`

## Requirements
- R1: After reset, `prog_start` and `load_abort` are 0, `buf_valid` is all zeros and every buffer word reads 0.
- R2: A write-to-buffer command is accepted only when its low data byte is 25h and it immediately follows AAh written at low address 555h and then 55h written at low address 2AAh. Low address means bits 10:0 and low data means bits 7:0. A broken prefix leaves the block idle, so later count and load writes change no output.
- R3: A count write whose full data value exceeds 15 (the page size minus one) raises `load_abort` one cycle later.
- R4: The count write, every load and the confirm must carry the same sector as the command, taken from address bits 21:15. A mismatch raises `load_abort`.
- R5: Exactly count+1 load writes follow the count. Each one sets `buf_valid[a]` and buffer word `a` to its data, where `a` is address bits 3:0. `page_base` becomes the first load address with bits 3:0 cleared.
- R6: A load whose address bits 21:4 differ from those of the first load raises `load_abort`.
- R7: A load to an already filled location overwrites that word and still counts toward the total.
- R8: After the last load, any write other than low data byte 29h at the command's sector raises `load_abort`.
- R9: After a valid confirm, `prog_start` pulses high for exactly one cycle, in the cycle after the first clock edge that sees `eng_busy` low. No pulse occurs while `eng_busy` stays high.
- R10: While the engine runs, `eng_done` clears all buffer words and valid bits one cycle later and returns the block to idle.
- R11: `load_abort` stays high until AAh at 555h, 55h at 2AAh and F0h at 555h are written back to back. That sequence clears the flag and the buffer. An incomplete or wrong sequence leaves the flag set.
- R12: Writes that arrive while a confirmed page waits for or runs in the engine are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| eng_busy | input | 1 | Programming engine cannot accept a start |
| eng_done | input | 1 | Programming engine finished the page |
| prog_start | output | 1 | One-cycle start request to the engine |
| load_abort | output | 1 | Sticky flag for a broken load sequence |
| page_base | output | 22 | First address of the buffered page |
| buf_words | output | 256 | Buffer contents, word i at bits i*16 +: 16 |
| buf_valid | output | 16 | Per-word loaded flags |

## Verification
The bench uses the default parameters: 22 address bits, 16-bit words, a 16-word page and the sector field starting at bit 15. With these values the largest legal count of 15 and the first illegal count of 16 can both be reached with short sequences. All sixteen page slots can be filled, and sectors and pages can be told apart with small address offsets. A behavioural model runs beside the design and is compared on every clock. This covers the busy hold-off, the overwrite counting and the abort-reset corner cases cycle by cycle.

// File: rtl/flash_wbuf_loader.sv
module flash_wbuf_loader #(
  parameter int AW       = 22,
  parameter int DW       = 16,
  parameter int PG_BITS  = 4,
  parameter int SECT_LSB = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          eng_busy,
  input  logic                          eng_done,
  output logic                          prog_start,
  output logic                          load_abort,
  output logic [AW-1:0]                 page_base,
  output logic [(1<<PG_BITS)*DW-1:0]    buf_words,
  output logic [(1<<PG_BITS)-1:0]       buf_valid
);

  localparam int WORDS = 1 << PG_BITS;
  localparam int SW    = AW - SECT_LSB;
  localparam int PW    = AW - PG_BITS;

  typedef enum logic [2:0] {
    S_IDLE, S_CNT, S_LOAD, S_CONF, S_ARM, S_RUN, S_ABORT
  } st_t;

  st_t                st;
  logic [1:0]         pfx_q;
  logic [SW-1:0]      sect_q;
  logic [PW-1:0]      page_q;
  logic [PG_BITS-1:0] left_q;
  logic               first_q;
  logic [DW-1:0]      mem [WORDS];

  wire [7:0] cmd     = wr_data[7:0];
  wire       at_555  = wr_addr[10:0] == 11'h555;
  wire       at_2aa  = wr_addr[10:0] == 11'h2AA;
  wire       is_aa   = wr_en && at_555 && cmd == 8'hAA;
  wire       is_55   = wr_en && at_2aa && cmd == 8'h55;
  wire       is_f0   = wr_en && at_555 && cmd == 8'hF0;
  wire       sect_ok = wr_addr[AW-1:SECT_LSB] == sect_q;
  wire       page_ok = first_q || (wr_addr[AW-1:PG_BITS] == page_q);
  wire       cnt_bad = wr_data > DW'(WORDS - 1);
  wire [1:0] pfx_nx  = is_aa ? 2'd1 : (pfx_q == 2'd1 && is_55) ? 2'd2 : 2'd0;
  wire [PG_BITS-1:0] slot = wr_addr[PG_BITS-1:0];

  assign load_abort = (st == S_ABORT);
  assign page_base  = {page_q, {PG_BITS{1'b0}}};

  genvar gi;
  generate
    for (gi = 0; gi < WORDS; gi++) begin : g_out
      assign buf_words[gi*DW +: DW] = mem[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pfx_q      <= '0;
      sect_q     <= '0;
      page_q     <= '0;
      left_q     <= '0;
      first_q    <= 1'b0;
      prog_start <= 1'b0;
      buf_valid  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      prog_start <= 1'b0;
      case (st)
        S_IDLE: if (wr_en) begin
          if (pfx_q == 2'd2 && cmd == 8'h25) begin
            sect_q <= wr_addr[AW-1:SECT_LSB];
            st     <= S_CNT;
            pfx_q  <= '0;
          end else begin
            pfx_q <= pfx_nx;
          end
        end
        S_CNT: if (wr_en) begin
          if (!sect_ok || cnt_bad) begin
            st <= S_ABORT;
          end else begin
            left_q  <= wr_data[PG_BITS-1:0];
            first_q <= 1'b1;
            st      <= S_LOAD;
          end
        end
        S_LOAD: if (wr_en) begin
          if (!sect_ok || !page_ok) begin
            st <= S_ABORT;
          end else begin
            page_q          <= wr_addr[AW-1:PG_BITS];
            first_q         <= 1'b0;
            mem[slot]       <= wr_data;
            buf_valid[slot] <= 1'b1;
            if (left_q == '0) st <= S_CONF;
            else              left_q <= left_q - 1'b1;
          end
        end
        S_CONF: if (wr_en) begin
          st <= (cmd == 8'h29 && sect_ok) ? S_ARM : S_ABORT;
        end
        S_ARM: if (!eng_busy) begin
          prog_start <= 1'b1;
          st         <= S_RUN;
        end
        S_RUN: if (eng_done) begin
          buf_valid <= '0;
          for (int i = 0; i < WORDS; i++) mem[i] <= '0;
          st    <= S_IDLE;
          pfx_q <= '0;
        end
        S_ABORT: if (wr_en) begin
          if (pfx_q == 2'd2 && is_f0) begin
            buf_valid <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            st    <= S_IDLE;
            pfx_q <= '0;
          end else begin
            pfx_q <= pfx_nx;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_start_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !$past(eng_busy));

  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_abort |-> !prog_start);

  p_abort_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_abort && !(pfx_q == 2'd2 && is_f0)) |=> load_abort);

  p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CNT && wr_en && cnt_bad) |=> load_abort);

  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && eng_done) |=> (buf_valid == '0));

  p_run_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !eng_done) |=> $stable(buf_valid));

endmodule

// File: tb/tb_flash_wbuf_loader.sv
module tb_flash_wbuf_loader;
  localparam int AW = 22, DW = 16, NW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, eng_busy = 1'b0, eng_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic prog_start, load_abort;
  logic [AW-1:0] page_base;
  logic [NW*DW-1:0] buf_words;
  logic [NW-1:0] buf_valid;

  flash_wbuf_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_done(eng_done), .prog_start(prog_start),
    .load_abort(load_abort), .page_base(page_base), .buf_words(buf_words),
    .buf_valid(buf_valid));

  int checks = 0, errors = 0;
  string req = "R1";

  // behavioural reference: 0 idle,1 count,2 load,3 confirm,4 wait,5 running,6 aborted
  int m_mode, m_pfx, m_left, m_sect, m_page, lo, bt, sec, pg, off, np;
  bit m_first, m_start;
  int m_mem[NW];
  bit m_vld[NW];

  task automatic m_clear();
    for (int i = 0; i < NW; i++) begin m_mem[i] = 0; m_vld[i] = 0; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pfx = 0; m_left = 0; m_sect = 0; m_page = 0;
      m_first = 0; m_start = 0; m_clear();
    end else begin
      m_start = 0;
      if (m_mode == 4) begin
        if (!eng_busy) begin m_start = 1; m_mode = 5; end
      end else if (m_mode == 5) begin
        if (eng_done) begin m_clear(); m_mode = 0; m_pfx = 0; end
      end else if (wr_en) begin
        lo = int'(wr_addr) % 2048; bt = int'(wr_data) % 256;
        sec = int'(wr_addr) >> 15; pg = int'(wr_addr) >> 4; off = int'(wr_addr) % 16;
        np = (lo == 'h555 && bt == 'hAA) ? 1 : (m_pfx == 1 && lo == 'h2AA && bt == 'h55) ? 2 : 0;
        case (m_mode)
          0: if (m_pfx == 2 && bt == 'h25) begin m_sect = sec; m_mode = 1; m_pfx = 0; end
             else m_pfx = np;
          1: if (sec != m_sect || int'(wr_data) > 15) m_mode = 6;
             else begin m_left = int'(wr_data); m_first = 1; m_mode = 2; end
          2: if (sec != m_sect || (!m_first && pg != m_page)) m_mode = 6;
             else begin
               m_page = pg; m_first = 0; m_mem[off] = int'(wr_data); m_vld[off] = 1;
               if (m_left == 0) m_mode = 3; else m_left--;
             end
          3: m_mode = (bt == 'h29 && sec == m_sect) ? 4 : 6;
          6: if (m_pfx == 2 && lo == 'h555 && bt == 'hF0) begin m_clear(); m_mode = 0; m_pfx = 0; end
             else m_pfx = np;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("prog_start", prog_start, m_start);
      chk("load_abort", load_abort, m_mode == 6);
      chk("page_base", page_base, longint'(m_page) << 4);
      for (int i = 0; i < NW; i++) begin
        chk("buf_valid", buf_valid[i], m_vld[i]);
        chk("buf_word", buf_words[i*DW +: DW], m_mem[i]);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask
  task automatic abort_reset();
    unlock(); wr('h555, 'hF0);
  endtask
  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  localparam int SA = 5 << 15;
  localparam int SB = 9 << 15;
  localparam int PA = SA + 'h120;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    req = "R1"; idle(2);
    chk("reset abort R1", load_abort, 0);
    chk("reset valid R1", buf_valid, 0);

    // R5, R9, R10, R12: normal flow
    req = "R5";
    unlock(); wr(SA, 'h25); wr(SA + 3, 3);
    wr(PA + 2, 'h1111); wr(PA + 5, 'h2222); wr(PA + 0, 'h3333); wr(PA + 15, 'h4444);
    chk("valid mask R5", buf_valid, 16'h8025);
    chk("page_base R5", page_base, PA);
    req = "R9"; wr(SA + 7, 'h29); idle(2);
    req = "R12"; unlock(); wr(SA, 'h25); idle(2);
    chk("run ignores writes R12", buf_valid, 16'h8025);
    req = "R10"; done_pulse(); idle(2);
    chk("done clears R10", buf_valid, 0);

    // R7 overwrite and R9 busy hold-off
    req = "R7";
    unlock(); wr(SA, 'h25); wr(SA, 2);
    wr(PA + 3, 'hAAA1); wr(PA + 3, 'hAAA2); wr(PA + 4, 'hBBBB);
    chk("overwrite word R7", buf_words[3*DW +: DW], 'hAAA2);
    req = "R9"; eng_busy = 1'b1; wr(SA, 'h29); idle(6);
    chk("held while busy R9", prog_start, 0);
    eng_busy = 1'b0; idle(3); done_pulse(); idle(2);

    // R2 broken prefixes
    req = "R2";
    wr('h555, 'hAA); wr('h2AA, 'h56); wr(SA, 'h25); wr(SA, 1); wr(PA, 'h5555); wr(PA + 1, 'h6666);
    wr('h555, 'hAA); wr('h2AB, 'h55); wr(SA, 'h25); wr(SA, 0); wr(PA, 'h7777);
    unlock(); wr(SA, 'h24); wr(SA, 0); wr(PA, 'h8888);
    chk("broken prefix R2", buf_valid, 0);
    unlock(); wr(SA + 'h100, 'h1325); wr(SA, 0); wr(PA + 9, 'h9999);
    chk("high data bits ignored R2", buf_valid, 16'h0200);
    wr(SA, 'h29); idle(3); done_pulse(); idle(2);

    // R3 count limit, R11 reset sequence
    req = "R3";
    unlock(); wr(SA, 'h25); wr(SA, 16);
    chk("count 16 aborts R3", load_abort, 1);
    req = "R11";
    wr(PA, 'h1234); unlock(); wr('h555, 'hF1); wr('h555, 'hAA); wr('h555, 'hF0);
    chk("abort sticky R11", load_abort, 1);
    abort_reset(); idle(1);
    chk("abort cleared R11", load_abort, 0);

    // R4 sector mismatch on count and on load
    req = "R4";
    unlock(); wr(SA, 'h25); wr(SB, 1); idle(1); abort_reset();
    unlock(); wr(SA, 'h25); wr(SA, 1); wr(PA, 'h0101); wr(SB + 'h120, 'h0202);
    chk("load sector mismatch R4", load_abort, 1);
    abort_reset(); idle(1);

    // R6 page violation
    req = "R6";
    unlock(); wr(SA, 'h25); wr(SA, 2); wr(PA + 1, 'h0A0A); wr(PA + 'h10, 'h0B0B);
    chk("out of page R6", load_abort, 1);
    abort_reset(); idle(1);

    // R8 bad confirm: wrong data, then wrong sector
    req = "R8";
    unlock(); wr(SA, 'h25); wr(SA, 0); wr(PA, 'h0C0C); wr(PA + 1, 'h0D0D);
    chk("extra load aborts R8", load_abort, 1);
    abort_reset();
    unlock(); wr(SA, 'h25); wr(SA, 0); wr(PA, 'h0E0E); wr(SB, 'h29);
    chk("confirm other sector R8", load_abort, 1);
    abort_reset(); idle(1);

    // R5 full page at maximum count
    req = "R5";
    unlock(); wr(SB, 'h25); wr(SB, 15);
    for (int i = 0; i < NW; i++) wr(SB + 'h40 + i, 'h100 + i * 7);
    chk("full page valid R5", buf_valid, 16'hFFFF);
    wr(SB, 'h29); idle(3); done_pulse(); idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule